// File: doc/BRIEF.md
# Dual-Processor Shared Memory Switch Controller

This block controls a switch that sits between two processors and their shared memory buses. With the switch closed, the two buses become one joined bus that reaches every shared module, and only the processor holding control may drive it. With the switch open, each processor works only on the modules on its own side. Each side owns a control flag. The two flags are coupled so that exactly one side holds control at any time. Control moves only when the holder gives it up.

Each side also owns a request flag that its software can set and clear. Only the holder's request sets the switch position. The position follows that request after a programmable number of cycles, which stands for the bounded actuation time. A shutdown input per processor forces failover. While one side is down, the other side takes control, the switch is held closed, and the status reads closed. This lasts until the stopped side is powered up again.

Top module: `ssw_ctrl`

## Requirements
- R1: After reset, processor 0 holds control (`ctl_flag` = 2'b01), the switch is open (`sw_closed` = 0), both request flags are 0 and `full_access` is 2'b00.
- R2: Exactly one bit of `ctl_flag` is set on every cycle after reset. Bit i set means processor i holds control.
- R3: When neither side is shut down, a `ctl_clr` pulse from the holder hands control to the peer on the next cycle. A `ctl_clr` pulse from the side that does not hold control has no effect.
- R4: A `req_set[i]` pulse sets `req_flag[i]` and a `req_clr[i]` pulse clears it on the next cycle. If both arrive in the same cycle, the clear wins. A request flag value of 1 asks for the switch to be closed.
- R5: A change in the request flag of the side that does not hold control never moves the switch.
- R6: When neither side is down and the holder's request differs from `sw_closed`, `sw_closed` takes the requested value at the (`act_dly`+1)-th clock edge after the request flag changes, and not earlier.
- R7: If the holder's request returns to the current switch position before the delay ends, the switch does not move and the delay count starts again from zero.
- R8: One cycle after either `cpu_down` input is seen high, `sw_closed` is 1. It stays 1 for as long as any `cpu_down` is high, whatever the request flags say. If exactly one side is down, control is with the other side.
- R9: A control clear that arrives in the same cycle as the peer's shutdown is ignored, so control stays with the running processor.
- R10: `full_access[i]` is 1 only when the switch is closed, processor i holds control and is not down. At most one bit is set.
- R11: After the shutdown input falls, the switch again follows the holder's request with the delay of R6, counted from the first edge at which no side is down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| act_dly | input | CNT_W | Actuation delay in cycles |
| ctl_clr | input | 2 | Per-side pulse: software clear of own control flag |
| req_set | input | 2 | Per-side pulse: set own request flag |
| req_clr | input | 2 | Per-side pulse: clear own request flag |
| cpu_down | input | 2 | Per-side level: processor is shut down |
| ctl_flag | output | 2 | Control flags, one-hot |
| req_flag | output | 2 | Request flags (1 = close) |
| sw_closed | output | 1 | Switch status, 1 = closed |
| full_access | output | 2 | Side i may use the joined bus |

## Verification
The checker asserts the one-hot control flags, the handover and failover steps, the rule that the switch holds still when the holder's request matches it, and the limits on joined-bus access. These are checked on every cycle. Only the bench scenarios can show the exact actuation latency, the restart of the delay when the request reverses, that non-holder requests are ignored, the dropped clear during a peer shutdown, and the recovery after power-up.

// File: rtl/ssw_pkg.sv
// Package: shared constants and helpers for the shared memory switch controller.
// Assumes exactly two processors share the switch.
package ssw_pkg;
    localparam int NSIDE = 2;

    typedef logic side_t;

    // Returns the index of the other processor.
    function automatic side_t peer_of(input side_t s);
        return ~s;
    endfunction
endpackage

// File: rtl/ssw_ctl_hold.sv
// Module: holds which processor owns control status.
// Handover happens only when the holder clears its own flag while both run.
// Failover moves control to the survivor when exactly one side is down.
// Assumes ctl_clr and down are synchronous to clk.
module ssw_ctl_hold
    import ssw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSIDE-1:0] ctl_clr,
    input  logic [NSIDE-1:0] down,
    output side_t            holder,
    output logic [NSIDE-1:0] ctl_flag
);
    side_t holder_q;
    side_t holder_d;
    side_t other;

    // Peer of the present holder.
    always_comb other = peer_of(holder_q);

    // Next holder: failover first, then a voluntary release.
    always_comb begin
        holder_d = holder_q;
        if (down[holder_q] && !down[other]) begin
            holder_d = other;
        end else if ((down == '0) && ctl_clr[holder_q]) begin
            holder_d = other;
        end
    end

    // Holder register, processor 0 after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) holder_q <= 1'b0;
        else        holder_q <= holder_d;
    end

    // Decode the holder into per-side flags.
    always_comb begin
        ctl_flag = '0;
        ctl_flag[holder_q] = 1'b1;
    end

    assign holder = holder_q;
endmodule

// File: rtl/ssw_req_bank.sv
// Module: per-side software request flags (1 = ask for a closed switch).
// A clear pulse has priority over a set pulse in the same cycle.
module ssw_req_bank
    import ssw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSIDE-1:0] req_set,
    input  logic [NSIDE-1:0] req_clr,
    output logic [NSIDE-1:0] req_flag
);
    for (genvar i = 0; i < NSIDE; i++) begin : g_side
        logic flag_q;

        // One request flag for side i.
        always_ff @(posedge clk) begin
            if (!rst_n)          flag_q <= 1'b0;
            else if (req_clr[i]) flag_q <= 1'b0;
            else if (req_set[i]) flag_q <= 1'b1;
        end

        assign req_flag[i] = flag_q;
    end
endmodule

// File: rtl/ssw_actuator.sv
// Module: switch position with delayed actuation.
// The position moves to the target after it has differed for dly+1 edges.
// force_close holds the switch closed and restarts the count.
module ssw_actuator #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             target,
    input  logic             force_close,
    input  logic [CNT_W-1:0] dly,
    output logic             closed
);
    logic             closed_q;
    logic [CNT_W-1:0] cnt_q;
    logic             differ;

    // Target and position disagree.
    always_comb differ = (target != closed_q);

    // Delay counter and switch position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            closed_q <= 1'b0;
            cnt_q    <= '0;
        end else if (force_close) begin
            closed_q <= 1'b1;
            cnt_q    <= '0;
        end else if (!differ) begin
            cnt_q    <= '0;
        end else if (cnt_q >= dly) begin
            closed_q <= target;
            cnt_q    <= '0;
        end else begin
            cnt_q    <= cnt_q + 1'b1;
        end
    end

    assign closed = closed_q;
endmodule

// File: rtl/ssw_ctrl.sv
// Module: top of the shared memory switch controller.
// Joins the control holder, the request flags and the actuator.
// Assumes all inputs are synchronous to clk; the reset is synchronous and active low.
module ssw_ctrl
    import ssw_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] act_dly,
    input  logic [1:0]       ctl_clr,
    input  logic [1:0]       req_set,
    input  logic [1:0]       req_clr,
    input  logic [1:0]       cpu_down,
    output logic [1:0]       ctl_flag,
    output logic [1:0]       req_flag,
    output logic             sw_closed,
    output logic [1:0]       full_access
);
    side_t holder;
    logic  target;
    logic  any_down;

    ssw_ctl_hold u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_clr  (ctl_clr),
        .down     (cpu_down),
        .holder   (holder),
        .ctl_flag (ctl_flag)
    );

    ssw_req_bank u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_set  (req_set),
        .req_clr  (req_clr),
        .req_flag (req_flag)
    );

    // Only the holder's request steers the switch; any shutdown forces it closed.
    always_comb begin
        target   = req_flag[holder];
        any_down = |cpu_down;
    end

    ssw_actuator #(.CNT_W(CNT_W)) u_act (
        .clk         (clk),
        .rst_n       (rst_n),
        .target      (target),
        .force_close (any_down),
        .dly         (act_dly),
        .closed      (sw_closed)
    );

    // Joined-bus grant: closed switch, holding side, side running.
    for (genvar i = 0; i < NSIDE; i++) begin : g_acc
        assign full_access[i] = sw_closed & ctl_flag[i] & ~cpu_down[i];
    end
endmodule

// File: rtl/ssw_ctrl_chk.sv
// Module: assertion checker for ssw_ctrl, attached with bind.
module ssw_ctrl_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] act_dly,
    input logic [1:0]       ctl_clr,
    input logic [1:0]       req_set,
    input logic [1:0]       req_clr,
    input logic [1:0]       cpu_down,
    input logic [1:0]       ctl_flag,
    input logic [1:0]       req_flag,
    input logic             sw_closed,
    input logic [1:0]       full_access
);
    // R1: reset state appears one edge after reset is sampled.
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (ctl_flag == 2'b01 && !sw_closed && req_flag == 2'b00));

    // R2: exactly one holder.
    p_one_holder_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ctl_flag) == 1);

    // R3: holder release hands control over.
    p_handover0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_flag[0] && ctl_clr[0] && cpu_down == 2'b00) |=> ctl_flag[1]);
    p_handover1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_flag[1] && ctl_clr[1] && cpu_down == 2'b00) |=> ctl_flag[0]);

    // R3: no change without a release or shutdown.
    p_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_down == 2'b00 && (ctl_clr & ctl_flag) == 2'b00) |=> $stable(ctl_flag));

    // R5, R7: switch holds while the holder's request matches it.
    p_hold_still_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_down == 2'b00 && sw_closed == (ctl_flag[0] ? req_flag[0] : req_flag[1]))
        |=> $stable(sw_closed));

    // R8: shutdown forces closed and moves control to the survivor.
    p_fail0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_down == 2'b01) |=> (sw_closed && ctl_flag == 2'b10));
    p_fail1_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_down == 2'b10) |=> (sw_closed && ctl_flag == 2'b01));
    p_both_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_down == 2'b11) |=> sw_closed);

    // R10: joined-bus access is exclusive and needs a closed switch.
    p_access_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(full_access) <= 1);
    p_access_closed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (full_access != 2'b00) |-> (sw_closed && (full_access & ctl_flag) == full_access));
endmodule

bind ssw_ctrl ssw_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .act_dly     (act_dly),
    .ctl_clr     (ctl_clr),
    .req_set     (req_set),
    .req_clr     (req_clr),
    .cpu_down    (cpu_down),
    .ctl_flag    (ctl_flag),
    .req_flag    (req_flag),
    .sw_closed   (sw_closed),
    .full_access (full_access)
);

// File: tb/tb_ssw_ctrl.sv
module tb_ssw_ctrl;
    localparam int CNT_W = 8;
    localparam int DLY   = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] act_dly = CNT_W'(DLY);
    logic [1:0]       ctl_clr = '0;
    logic [1:0]       req_set = '0;
    logic [1:0]       req_clr = '0;
    logic [1:0]       cpu_down = '0;
    logic [1:0]       ctl_flag;
    logic [1:0]       req_flag;
    logic             sw_closed;
    logic [1:0]       full_access;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    ssw_ctrl #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .act_dly(act_dly),
        .ctl_clr(ctl_clr), .req_set(req_set), .req_clr(req_clr),
        .cpu_down(cpu_down), .ctl_flag(ctl_flag), .req_flag(req_flag),
        .sw_closed(sw_closed), .full_access(full_access)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    // One-cycle pulse on the given pulse inputs.
    task automatic pulse(input logic [1:0] cc, input logic [1:0] rs, input logic [1:0] rc);
        ctl_clr = cc; req_set = rs; req_clr = rc;
        step(1);
        ctl_clr = '0; req_set = '0; req_clr = '0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        chk("R1 ctl", {6'd0, ctl_flag}, 8'h01);
        chk("R1 closed", {7'd0, sw_closed}, 8'h00);
        chk("R1 req", {6'd0, req_flag}, 8'h00);
        chk("R1 access", {6'd0, full_access}, 8'h00);
    endtask

    task automatic t_req_bank;
        pulse(2'b00, 2'b10, 2'b00);
        chk("R4 set", {6'd0, req_flag}, 8'h02);
        pulse(2'b00, 2'b00, 2'b10);
        chk("R4 clr", {6'd0, req_flag}, 8'h00);
        pulse(2'b00, 2'b10, 2'b10);
        chk("R4 clr wins", {6'd0, req_flag}, 8'h00);
    endtask

    task automatic t_nonholder;
        pulse(2'b00, 2'b10, 2'b00);
        step(DLY + 3);
        chk("R5 non-holder req", {7'd0, sw_closed}, 8'h00);
        pulse(2'b00, 2'b00, 2'b10);
    endtask

    task automatic t_close_delay;
        pulse(2'b00, 2'b01, 2'b00);
        step(DLY);
        chk("R6 still open", {7'd0, sw_closed}, 8'h00);
        step(1);
        chk("R6 closed", {7'd0, sw_closed}, 8'h01);
        chk("R10 access 0", {6'd0, full_access}, 8'h01);
        chk("R2 onehot", {6'd0, ctl_flag}, 8'h01);
    endtask

    task automatic t_revert;
        pulse(2'b00, 2'b00, 2'b01);
        step(1);
        pulse(2'b00, 2'b01, 2'b00);
        step(DLY + 3);
        chk("R7 no move", {7'd0, sw_closed}, 8'h01);
        pulse(2'b00, 2'b00, 2'b01);
        step(DLY);
        chk("R7 restart open late", {7'd0, sw_closed}, 8'h01);
        step(1);
        chk("R7 opened", {7'd0, sw_closed}, 8'h00);
        chk("R10 open no access", {6'd0, full_access}, 8'h00);
    endtask

    task automatic t_handover;
        pulse(2'b10, 2'b00, 2'b00);
        chk("R3 non-holder clr", {6'd0, ctl_flag}, 8'h01);
        pulse(2'b01, 2'b00, 2'b00);
        chk("R3 handover", {6'd0, ctl_flag}, 8'h02);
        pulse(2'b00, 2'b10, 2'b00);
        step(DLY);
        chk("R5 holder1 wait", {7'd0, sw_closed}, 8'h00);
        step(1);
        chk("R5 holder1 closed", {7'd0, sw_closed}, 8'h01);
        chk("R10 access 1", {6'd0, full_access}, 8'h02);
        pulse(2'b00, 2'b00, 2'b10);
        step(DLY + 1);
        chk("R6 reopen", {7'd0, sw_closed}, 8'h00);
    endtask

    task automatic t_shutdown;
        cpu_down = 2'b01;
        pulse(2'b10, 2'b00, 2'b00);
        chk("R9 clr ignored", {6'd0, ctl_flag}, 8'h02);
        chk("R8 forced closed", {7'd0, sw_closed}, 8'h01);
        chk("R10 survivor access", {6'd0, full_access}, 8'h02);
        step(DLY + 3);
        chk("R8 held closed", {7'd0, sw_closed}, 8'h01);
        cpu_down = 2'b00;
        step(DLY);
        chk("R11 not yet open", {7'd0, sw_closed}, 8'h01);
        step(1);
        chk("R11 reopened", {7'd0, sw_closed}, 8'h00);
        cpu_down = 2'b10;
        step(1);
        chk("R8 holder down ctl", {6'd0, ctl_flag}, 8'h01);
        chk("R8 holder down closed", {7'd0, sw_closed}, 8'h01);
        cpu_down = 2'b00;
        step(DLY + 1);
        chk("R11 reopen after holder", {7'd0, sw_closed}, 8'h00);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #1;
        t_reset();
        t_req_bank();
        t_nonholder();
        t_close_delay();
        t_revert();
        t_handover();
        t_shutdown();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule